// File: doc/BRIEF.md
# Flash Bank Busy and Access Guard

This block sits between the CPU and a multi-bank on-chip flash array and keeps track of which bank has a program, erase or protection operation in flight. A start strobe marks the target bank busy. From then on, any CPU read of that bank returns an invalid all-ones word and raises a one-cycle trap carrying a fixed code. Any CPU write to that bank is dropped before it reaches the array. Banks that are not busy pass reads and writes through unchanged.

A program or erase operation can be suspended, which frees its bank for reading, and later resumed, which marks the bank busy again. A start can request a lock. While that operation is active, the lock freezes the software-writable configuration field of the control register. If the supply drops below the internal threshold while an operation is active, the operation is abandoned at once and every bank returns to read mode. A sticky flag then tells software that the write has to be repeated.

A single 16-bit control register presents the status. The low byte is read-only status and the high byte is the configuration field.

Top module: `flash_bank_guard`

## Requirements
- R1: When `op_start` is high while no operation is active, the bank given by `op_bank` becomes busy from the next cycle. Status bits [3:0] hold the one-hot busy vector, bit 7 shows the active flag, and bit 4 shows the lock requested by `op_lock`. `op_kind` is encoded as 00 program, 01 erase and 10 protect.
- R2: A protect start (`op_kind`=10) always marks bank 2 busy, whatever the value of `op_bank`.
- R3: Consider a read request in cycle t. If its bank is busy, then in cycle t+1 `rd_data` is all ones, `trap_pulse` is high for exactly one cycle and `trap_code` is 0x009B. Otherwise `rd_data` carries `arr_rdata`, `trap_pulse` is low and `trap_code` is 0.
- R4: `arr_wr_en` follows `wr_req` in the same cycle, except when the bank selected by `wr_bank` is busy; then it stays low.
- R5: `op_done` during an active operation clears the busy bits, the lock bit and the active flag on the next cycle.
- R6: `op_suspend` of an active program or erase clears the busy bits and sets the suspended bit (bit 5). `op_resume` restores the busy bit of the target bank and clears bit 5. A suspend of a protect operation has no effect.
- R7: A register write loads `reg_wdata` into status bits [15:8], unless an operation is active with its lock set. In that case the field keeps its value.
- R8: `lv_detect` high during an active operation clears the busy, lock, suspended and active bits and sets the abort flag (bit 6) on the next cycle. The abort flag stays set until the next start. `lv_detect` while idle has no effect.
- R9: After reset the status register reads 0x0000, `rd_data` is 0 and `trap_pulse` is low.
- R10: A start strobe while an operation is active, whether running or suspended, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the configuration field |
| reg_wdata | input | 8 | Configuration field write data |
| reg_rdata | output | 16 | Control/status register read value |
| op_start | input | 1 | Operation start strobe |
| op_kind | input | 2 | Operation kind: 00 program, 01 erase, 10 protect |
| op_bank | input | 2 | Target bank of the operation |
| op_lock | input | 1 | Request register lock for this operation |
| op_done | input | 1 | Operation completion strobe |
| op_suspend | input | 1 | Suspend strobe |
| op_resume | input | 1 | Resume strobe |
| lv_detect | input | 1 | Supply below internal threshold |
| rd_req | input | 1 | CPU read request |
| rd_bank | input | 2 | Bank addressed by the read |
| arr_rdata | input | 16 | Data returned by the flash array |
| rd_data | output | 16 | Read data to the CPU, registered |
| trap_pulse | output | 1 | One-cycle trap on a read of a busy bank |
| trap_code | output | 16 | Trap code, 0x009B with the pulse, else 0 |
| wr_req | input | 1 | CPU write request |
| wr_bank | input | 2 | Bank addressed by the write |
| arr_wr_en | output | 1 | Gated write enable to the array |

## Verification
The assertions assume that each strobe lasts a single cycle and that `op_done`, `op_suspend` and `op_resume` come only when an operation is active. They also assume that a protect operation is never resumed and that bank indices stay below the bank count. The bench drives each strobe for exactly one cycle, at the falling edge. It sweeps every operation kind against every bank. For each pair it probes reads and writes on all banks, then goes through suspend/resume, the lock, a rejected second start, and either completion or a supply-drop abort. Expected values come from a small status model kept in the bench.

// File: rtl/flash_bank_guard_pkg.sv
// Package: shared encodings and status-register field positions for the
// flash bank guard. Assumes at most four banks fit the status busy field.
package flash_bank_guard_pkg;
    typedef enum logic [1:0] {
        OP_PROGRAM = 2'b00,
        OP_ERASE   = 2'b01,
        OP_PROTECT = 2'b10,
        OP_RSVD    = 2'b11
    } op_kind_e;

    localparam int          STAT_BUSY_W  = 4;
    localparam int          STAT_LOCK    = 4;
    localparam int          STAT_SUSP    = 5;
    localparam int          STAT_ABORT   = 6;
    localparam int          STAT_ACTIVE  = 7;
    localparam int          CFG_LSB      = 8;
    localparam int          CFG_W        = 8;
    localparam logic [15:0] BUSY_TRAP_ID = 16'h009B;
endpackage

// File: rtl/fbg_busy_tracker.sv
// Module: fbg_busy_tracker
// Holds the per-bank busy vector and the state of the one operation that may
// be in flight: active, suspended, locked, and the sticky abort flag.
// Priority order: supply drop, then done, then suspend, then resume, then start.
// Assumes strobes last one cycle; a start while active is ignored.
module fbg_busy_tracker
    import flash_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PROT_BANK = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic [1:0]           op_kind,
    input  logic [BANK_W-1:0]    op_bank,
    input  logic                 op_lock,
    input  logic                 op_done,
    input  logic                 op_suspend,
    input  logic                 op_resume,
    input  logic                 lv_detect,
    output logic [NUM_BANKS-1:0] busy,
    output logic                 lock,
    output logic                 suspended,
    output logic                 aborted,
    output logic                 active
);
    logic [NUM_BANKS-1:0] busy_q, tgt_q, tgt_d;
    logic                 lock_q, susp_q, abort_q, active_q, prot_q;
    logic                 is_prot;

    // Decode the target bank of a start request into a one-hot vector.
    always_comb begin
        is_prot = (op_kind == OP_PROTECT);
        tgt_d   = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (is_prot ? (i == PROT_BANK) : (op_bank == BANK_W'(i)))
                tgt_d[i] = 1'b1;
        end
    end

    // Sequence the operation state: abort, completion, suspend, resume, start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= '0;
            tgt_q    <= '0;
            lock_q   <= 1'b0;
            susp_q   <= 1'b0;
            abort_q  <= 1'b0;
            active_q <= 1'b0;
            prot_q   <= 1'b0;
        end else if (lv_detect && active_q) begin
            busy_q   <= '0;
            lock_q   <= 1'b0;
            susp_q   <= 1'b0;
            active_q <= 1'b0;
            abort_q  <= 1'b1;
        end else if (active_q) begin
            if (op_done) begin
                busy_q   <= '0;
                lock_q   <= 1'b0;
                susp_q   <= 1'b0;
                active_q <= 1'b0;
            end else if (op_suspend && !susp_q && !prot_q) begin
                busy_q <= '0;
                susp_q <= 1'b1;
            end else if (op_resume && susp_q) begin
                busy_q <= tgt_q;
                susp_q <= 1'b0;
            end
        end else if (op_start) begin
            busy_q   <= tgt_d;
            tgt_q    <= tgt_d;
            lock_q   <= op_lock;
            susp_q   <= 1'b0;
            abort_q  <= 1'b0;
            active_q <= 1'b1;
            prot_q   <= is_prot;
        end
    end

    assign busy      = busy_q;
    assign lock      = lock_q;
    assign suspended = susp_q;
    assign aborted   = abort_q;
    assign active    = active_q;

    // At most one bank is ever busy.
    assert_busy_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q));
    // An accepted start marks a bank busy and makes the operation active.
    assert_start_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !active_q && !lv_detect) |=> (busy_q != '0) && active_q);
    // A protect start always lands on the protection bank.
    assert_prot_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !active_q && (op_kind == OP_PROTECT)) |=> busy_q[PROT_BANK]);
    // Completion frees every bank and the lock.
    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && active_q) |=> (busy_q == '0) && !lock_q && !active_q);
    // A busy bank and the suspended state never coexist.
    assert_susp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |-> (busy_q == '0) && active_q);
    // A supply drop during an operation leaves every bank in read mode.
    assert_lv_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_detect && active_q) |=> (busy_q == '0) && aborted && !active_q);
    // A start during an active operation leaves the target untouched.
    assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && active_q) |=> $stable(tgt_q));
endmodule

// File: rtl/fbg_access_guard.sv
// Module: fbg_access_guard
// Filters CPU accesses against the busy vector. A read of a busy bank returns
// all ones and pulses the trap one cycle later; a write to a busy bank is
// dropped in the same cycle. Assumes bank indices below NUM_BANKS.
module fbg_access_guard
    import flash_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] busy,
    input  logic                 rd_req,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic [DATA_W-1:0]    arr_rdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 trap_pulse,
    output logic [15:0]          trap_code,
    input  logic                 wr_req,
    input  logic [BANK_W-1:0]    wr_bank,
    output logic                 arr_wr_en
);
    logic rd_hit_busy;
    logic wr_hit_busy;

    // Look up the busy state of the addressed banks.
    always_comb begin
        rd_hit_busy = busy[rd_bank];
        wr_hit_busy = busy[wr_bank];
    end

    // Register read data and the trap pulse for each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            trap_pulse <= 1'b0;
            trap_code  <= '0;
        end else begin
            trap_pulse <= rd_req && rd_hit_busy;
            trap_code  <= (rd_req && rd_hit_busy) ? BUSY_TRAP_ID : 16'h0000;
            if (rd_req)
                rd_data <= rd_hit_busy ? {DATA_W{1'b1}} : arr_rdata;
        end
    end

    // Pass the write enable through only for a bank in read mode.
    assign arr_wr_en = wr_req && !wr_hit_busy;

    // A read of a busy bank yields invalid data and the trap in the next cycle.
    assert_busy_read_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy[rd_bank]) |=> trap_pulse && (trap_code == BUSY_TRAP_ID)
                                      && (rd_data == {DATA_W{1'b1}}));
    // With no read in a cycle there is no trap in the next one.
    assert_trap_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !trap_pulse);
    // A write never reaches a busy bank.
    assert_busy_write_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && busy[wr_bank]) |-> !arr_wr_en);
endmodule

// File: rtl/fbg_ctrl_reg.sv
// Module: fbg_ctrl_reg
// Holds the software configuration field and assembles the status register.
// The field cannot be written while a locked operation is active. The status
// bits are read-only. Assumes NUM_BANKS does not exceed the busy field width.
module fbg_ctrl_reg
    import flash_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [CFG_W-1:0]     reg_wdata,
    input  logic [NUM_BANKS-1:0] busy,
    input  logic                 lock,
    input  logic                 suspended,
    input  logic                 aborted,
    input  logic                 active,
    output logic [15:0]          reg_rdata
);
    logic [CFG_W-1:0] cfg_q;
    logic             wr_blocked;

    assign wr_blocked = lock && active;

    // Load the configuration field unless a locked operation is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (reg_wr && !wr_blocked)
            cfg_q <= reg_wdata;
    end

    // Pack the status and configuration fields into the read value.
    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[NUM_BANKS-1:0]        = busy;
        reg_rdata[STAT_LOCK]            = lock;
        reg_rdata[STAT_SUSP]            = suspended;
        reg_rdata[STAT_ABORT]           = aborted;
        reg_rdata[STAT_ACTIVE]          = active;
        reg_rdata[CFG_LSB +: CFG_W]     = cfg_q;
    end

    // Writes attempted under an active lock leave the field unchanged.
    assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && lock && active) |=> $stable(cfg_q));
    // Lock is only ever held by an active operation.
    assert_lock_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> active);
endmodule

// File: rtl/flash_bank_guard.sv
// Module: flash_bank_guard (top)
// Ties the busy tracker, the access guard and the control register together.
// Assumes one operation at a time and single-cycle strobes.
module flash_bank_guard
    import flash_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16,
    parameter int PROT_BANK = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [BANK_W-1:0] op_bank,
    input  logic              op_lock,
    input  logic              op_done,
    input  logic              op_suspend,
    input  logic              op_resume,
    input  logic              lv_detect,
    input  logic              rd_req,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              trap_pulse,
    output logic [15:0]       trap_code,
    input  logic              wr_req,
    input  logic [BANK_W-1:0] wr_bank,
    output logic              arr_wr_en
);
    logic [NUM_BANKS-1:0] busy;
    logic                 lock, suspended, aborted, active;

    fbg_busy_tracker #(.NUM_BANKS(NUM_BANKS), .PROT_BANK(PROT_BANK)) u_track (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_kind(op_kind), .op_bank(op_bank),
        .op_lock(op_lock), .op_done(op_done), .op_suspend(op_suspend),
        .op_resume(op_resume), .lv_detect(lv_detect),
        .busy(busy), .lock(lock), .suspended(suspended),
        .aborted(aborted), .active(active)
    );

    fbg_access_guard #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .rd_req(rd_req), .rd_bank(rd_bank), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .trap_pulse(trap_pulse), .trap_code(trap_code),
        .wr_req(wr_req), .wr_bank(wr_bank), .arr_wr_en(arr_wr_en)
    );

    fbg_ctrl_reg #(.NUM_BANKS(NUM_BANKS)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .busy(busy), .lock(lock), .suspended(suspended),
        .aborted(aborted), .active(active), .reg_rdata(reg_rdata)
    );

    // The status register is all zeros right after reset.
    assert_reset_zero_R9: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 16'h0000) && !trap_pulse);
endmodule

// File: tb/sim_flash_bank_guard.sv
module sim_flash_bank_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [1:0]  op_bank = '0;
    logic        op_lock = 1'b0;
    logic        op_done = 1'b0;
    logic        op_suspend = 1'b0;
    logic        op_resume = 1'b0;
    logic        lv_detect = 1'b0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_bank = '0;
    logic [15:0] arr_rdata = '0;
    logic [15:0] rd_data;
    logic        trap_pulse;
    logic [15:0] trap_code;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic        arr_wr_en;

    int checks = 0;
    int fails  = 0;
    logic done_flag = 1'b0;

    always #10 clk = ~clk;

    flash_bank_guard u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .op_start(op_start), .op_kind(op_kind),
        .op_bank(op_bank), .op_lock(op_lock), .op_done(op_done),
        .op_suspend(op_suspend), .op_resume(op_resume), .lv_detect(lv_detect),
        .rd_req(rd_req), .rd_bank(rd_bank), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .trap_pulse(trap_pulse), .trap_code(trap_code),
        .wr_req(wr_req), .wr_bank(wr_bank), .arr_wr_en(arr_wr_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] stat(input logic [7:0] c, input logic act,
        input logic ab, input logic su, input logic lk, input logic [3:0] b);
        return {c, act, ab, su, lk, b};
    endfunction

    initial begin
        #4000000;
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  cfg_m;
        logic        ab_m;
        logic [3:0]  oh;
        logic [1:0]  tgt;
        logic        lk;
        logic [7:0]  wv;
        cfg_m = '0;
        ab_m  = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        chk("R9 status", 32'(reg_rdata), 32'h0000);
        chk("R9 rd_data", 32'(rd_data), 32'h0000);
        chk("R9 trap", 32'(trap_pulse), 32'h0);

        for (int k = 0; k < 3; k++) begin
            for (int bk = 0; bk < 4; bk++) begin
                tgt = (k == 2) ? 2'd2 : 2'(bk);
                oh  = 4'b0001 << tgt;
                lk  = bk[0] ^ k[0];
                op_start = 1'b1; op_kind = 2'(k); op_bank = 2'(bk); op_lock = lk;
                step();
                op_start = 1'b0;
                ab_m = 1'b0;
                chk((k == 2) ? "R2 start" : "R1 start", 32'(reg_rdata),
                    32'(stat(cfg_m, 1'b1, 1'b0, 1'b0, lk, oh)));

                for (int b = 0; b < 4; b++) begin
                    rd_req = 1'b1; rd_bank = 2'(b);
                    arr_rdata = 16'hA000 | 16'(k << 8) | 16'(bk << 4) | 16'(b);
                    step();
                    rd_req = 1'b0;
                    chk("R3 data", 32'(rd_data),
                        (b == tgt) ? 32'hFFFF : 32'(16'hA000 | 16'(k << 8) | 16'(bk << 4) | 16'(b)));
                    chk("R3 trap", 32'(trap_pulse), (b == tgt) ? 32'h1 : 32'h0);
                    chk("R3 code", 32'(trap_code), (b == tgt) ? 32'h009B : 32'h0);
                end
                step();
                chk("R3 single pulse", 32'(trap_pulse), 32'h0);

                for (int b = 0; b < 4; b++) begin
                    wr_req = 1'b1; wr_bank = 2'(b);
                    #1;
                    chk("R4 write gate", 32'(arr_wr_en), (b == tgt) ? 32'h0 : 32'h1);
                    wr_req = 1'b0;
                    #1;
                    chk("R4 idle", 32'(arr_wr_en), 32'h0);
                end

                wv = 8'h30 + 8'(k * 4 + bk);
                reg_wr = 1'b1; reg_wdata = wv;
                step();
                reg_wr = 1'b0;
                if (!lk) cfg_m = wv;
                chk("R7 cfg write", 32'(reg_rdata),
                    32'(stat(cfg_m, 1'b1, 1'b0, 1'b0, lk, oh)));

                op_start = 1'b1; op_kind = 2'b00; op_bank = tgt ^ 2'd1; op_lock = ~lk;
                step();
                op_start = 1'b0;
                chk("R10 restart", 32'(reg_rdata),
                    32'(stat(cfg_m, 1'b1, 1'b0, 1'b0, lk, oh)));

                op_suspend = 1'b1;
                step();
                op_suspend = 1'b0;
                if (k != 2) begin
                    chk("R6 suspend", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b1, 1'b0, 1'b1, lk, 4'b0000)));
                    rd_req = 1'b1; rd_bank = tgt; arr_rdata = 16'h5A00 | 16'(bk);
                    step();
                    rd_req = 1'b0;
                    chk("R6 read during suspend", 32'(rd_data), 32'(16'h5A00 | 16'(bk)));
                    chk("R6 no trap", 32'(trap_pulse), 32'h0);
                    op_resume = 1'b1;
                    step();
                    op_resume = 1'b0;
                    chk("R6 resume", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b1, 1'b0, 1'b0, lk, oh)));
                end else begin
                    chk("R6 protect no suspend", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b1, 1'b0, 1'b0, lk, oh)));
                end

                if (bk == 1) begin
                    lv_detect = 1'b1;
                    step();
                    lv_detect = 1'b0;
                    ab_m = 1'b1;
                    chk("R8 abort", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000)));
                    lv_detect = 1'b1;
                    step();
                    lv_detect = 1'b0;
                    chk("R8 idle drop", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000)));
                end else begin
                    op_done = 1'b1;
                    step();
                    op_done = 1'b0;
                    chk("R5 done", 32'(reg_rdata),
                        32'(stat(cfg_m, 1'b0, ab_m, 1'b0, 1'b0, 4'b0000)));
                end

                wv = 8'hC0 + 8'(k * 4 + bk);
                reg_wr = 1'b1; reg_wdata = wv;
                step();
                reg_wr = 1'b0;
                cfg_m = wv;
                chk("R7 idle write", 32'(reg_rdata),
                    32'(stat(cfg_m, 1'b0, ab_m, 1'b0, 1'b0, 4'b0000)));
            end
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule